// File: doc/BRIEF.md
# Multi-Lane Three-Wire Thermometer Responder

This block answers a host as if four three-wire serial thermometers were wired in parallel to one shared command stream. Sensor `i` is carried on bit `i` of the data path. The host drives the emulated serial clock and reset with control-code writes. It sends command and data bits one at a time with data-code writes, and it collects serial output with read strobes. Each read returns one bit position of all four sensors packed into a single 4-bit word.

A command is 8 bits, shifted in LSB first. Three commands are recognised: start conversion (0xEE), read temperature (0xAA) and read configuration (0xAC). After a read command the block streams out the selected register of every sensor, one bit position per read. It clears its own shift state once the last bit has been delivered: 9 bits for temperature, 8 bits for configuration. Bits written after a complete command are collected into a data word. An unknown command raises a sticky error flag. The sensor registers come out of reset with fixed values and can be loaded through a side write port.

Top module: `thermo_lane_resp`

## Requirements
- R1: After `rst_ni` is released, `rd_data_o`, `rd_valid_o`, `err_o` and `data_word_o` are all zero. Every temperature register holds 44 (22 degrees in half-degree units) and every configuration register holds 0x02.
- R2: Control code 1 sets the clock-low flag and control code 2 clears it. A data code 0 (bit low) or 1 (bit high) shifts a command bit in, LSB first, only while the flag is set; when the flag is clear the bit is ignored.
- R3: When the eighth command bit completes 0xEE (start conversion), the command, the command bit count, the data word and the bit position are all cleared, so a new command can follow at once.
- R4: After command 0xAA, each read returns bit k of sensor i's temperature register in `rd_data_o[i]`, with k starting at 0. After the ninth read the block clears its shift state, so later reads return zero.
- R5: After command 0xAC, reads return the configuration registers in the same lane packing. The block clears its shift state after the eighth read.
- R6: Data code 2 (read enable) sets the bit position to zero whether or not the clock-low flag is set, and it leaves the received command unchanged.
- R7: While the clock-low flag is set and a full command has been received, each data bit goes to the current bit position of `data_word_o`, LSB first: a bit-high code sets that bit. The position then advances.
- R8: A completed command other than 0xEE, 0xAA or 0xAC sets `err_o` on the following cycle, and reads then return zero.
- R9: Control code 0 (reset) clears the command, both bit positions, `data_word_o` and `err_o`, and leaves the clock-low flag unchanged.
- R10: A side-port write stores `side_wdata_i` into sensor `side_idx_i`. The target is the temperature register when `side_cfg_i` is 0 and the low 8 bits of the configuration register when it is 1.
- R11: Every accepted read pulses `rd_valid_o` for one cycle after the strobe. `rd_data_o` keeps its value between reads, and a read with no read command in force returns zero.
- R12: When several strobes arrive in the same cycle, a control write wins over a data write, and a data write wins over a read. A strobe that loses is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control-code write strobe |
| ctrl_code_i | input | 2 | 0 reset, 1 clock low, 2 clock high |
| data_we_i | input | 1 | Data-code write strobe |
| data_code_i | input | 2 | 0 bit low, 1 bit high, 2 read enable |
| rd_i | input | 1 | Host read strobe |
| rd_data_o | output | LANES | One bit position of every sensor, lane i in bit i |
| rd_valid_o | output | 1 | Read result valid, one cycle |
| err_o | output | 1 | Sticky unknown-command flag |
| data_word_o | output | DATA_W | Bits collected after a complete command |
| side_we_i | input | 1 | Side-port register write strobe |
| side_cfg_i | input | 1 | 0 temperature, 1 configuration |
| side_idx_i | input | $clog2(LANES) | Sensor index |
| side_wdata_i | input | TEMP_BITS | Register value |

## Verification
The bench gives the four temperature registers distinct patterns, so a lane swap or a reversed bit order shows up as a scoreboard mismatch rather than staying hidden behind identical values. It checks the read-length boundaries by reading exactly 8 or 9 times and then once more. A design that counts one bit short or one bit long returns a nonzero or shifted word on that extra read. It sends an all-ones pattern while the clock flag is clear. A design that accepts bits without the flag would decode an unknown command and set the error flag. It also rewinds a read partway through with read enable, checks that a reset code keeps the clock flag, and pairs strobes in one cycle. A wrong priority order shows up as an unexpected valid pulse or as a skipped bit position.

// File: rtl/thermo_pkg.sv
package thermo_pkg;
  localparam logic [1:0] CTL_RESET  = 2'd0;
  localparam logic [1:0] CTL_CLK_LO = 2'd1;
  localparam logic [1:0] CTL_CLK_HI = 2'd2;

  localparam logic [1:0] DAT_LOW    = 2'd0;
  localparam logic [1:0] DAT_HIGH   = 2'd1;
  localparam logic [1:0] DAT_RD_EN  = 2'd2;

  typedef enum logic [1:0] {
    RM_NONE = 2'd0,
    RM_TEMP = 2'd1,
    RM_CFG  = 2'd2
  } rd_mode_e;
endpackage

// File: rtl/thermo_sensor_bank.sv
module thermo_sensor_bank
  import thermo_pkg::*;
#(
  parameter int unsigned LANES     = 4,
  parameter int unsigned TEMP_BITS = 9,
  parameter int unsigned CFG_BITS  = 8,
  parameter int unsigned POS_W     = 5,
  parameter logic [TEMP_BITS-1:0] TEMP_RST = TEMP_BITS'(44),
  parameter logic [CFG_BITS-1:0]  CFG_RST  = CFG_BITS'(2)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       side_we_i,
  input  logic                       side_cfg_i,
  input  logic [$clog2(LANES)-1:0]   side_idx_i,
  input  logic [TEMP_BITS-1:0]       side_wdata_i,
  input  logic [POS_W-1:0]           pos_i,
  output logic [LANES-1:0]           temp_bits_o,
  output logic [LANES-1:0]           cfg_bits_o
);
  localparam int unsigned IDX_W = $clog2(LANES);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [TEMP_BITS-1:0] temp_q;
    logic [CFG_BITS-1:0]  cfg_q;
    logic [TEMP_BITS-1:0] temp_sh;
    logic [CFG_BITS-1:0]  cfg_sh;
    logic                 hit;

    assign hit = side_we_i && (side_idx_i == IDX_W'(l));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        temp_q <= TEMP_RST;
        cfg_q  <= CFG_RST;
      end else if (hit) begin
        if (side_cfg_i) cfg_q  <= side_wdata_i[CFG_BITS-1:0];
        else            temp_q <= side_wdata_i;
      end
    end

    // shift select: positions past the register width read as zero
    assign temp_sh = temp_q >> pos_i;
    assign cfg_sh  = cfg_q >> pos_i;
    assign temp_bits_o[l] = temp_sh[0];
    assign cfg_bits_o[l]  = cfg_sh[0];
  end
endmodule

// File: rtl/thermo_ctrl.sv
module thermo_ctrl
  import thermo_pkg::*;
#(
  parameter int unsigned CMD_W     = 8,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned TEMP_BITS = 9,
  parameter int unsigned CFG_BITS  = 8,
  parameter int unsigned POS_W     = 5,
  parameter logic [CMD_W-1:0] CMD_CONV    = 8'hEE,
  parameter logic [CMD_W-1:0] CMD_RD_TEMP = 8'hAA,
  parameter logic [CMD_W-1:0] CMD_RD_CFG  = 8'hAC
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [1:0]        ctrl_code_i,
  input  logic              data_we_i,
  input  logic [1:0]        data_code_i,
  input  logic              rd_i,
  output rd_mode_e          mode_o,
  output logic [POS_W-1:0]  pos_o,
  output logic              rd_take_o,
  output logic              clk_low_o,
  output logic              err_o,
  output logic [DATA_W-1:0] word_o
);
  localparam int unsigned CPW   = $clog2(CMD_W + 1);
  localparam int unsigned MAXRD = (TEMP_BITS > CFG_BITS) ? TEMP_BITS : CFG_BITS;
  localparam int unsigned MAXL  = (DATA_W > MAXRD) ? DATA_W : MAXRD;

  logic [CMD_W-1:0]  cmd_q, cmd_d;
  logic [CPW-1:0]    cpos_q, cpos_d;
  logic [POS_W-1:0]  dpos_q, dpos_d;
  logic [DATA_W-1:0] word_q, word_d;
  logic              err_q, err_d;
  logic              clk_lo_q, clk_lo_d;
  logic              clr;
  logic              ctrl_hit, data_hit, rd_hit;
  logic              cmd_full, bit_hi;
  logic [POS_W-1:0]  rd_last;
  rd_mode_e          mode;

  assign ctrl_hit = ctrl_we_i;
  assign data_hit = data_we_i && !ctrl_we_i;
  assign rd_hit   = rd_i && !ctrl_we_i && !data_we_i;
  assign cmd_full = (cpos_q == CPW'(CMD_W));
  assign bit_hi   = (data_code_i == DAT_HIGH);

  always_comb begin
    mode = RM_NONE;
    if (cmd_full) begin
      if (cmd_q == CMD_RD_TEMP)     mode = RM_TEMP;
      else if (cmd_q == CMD_RD_CFG) mode = RM_CFG;
    end
  end

  assign rd_last = (mode == RM_TEMP) ? POS_W'(TEMP_BITS - 1) : POS_W'(CFG_BITS - 1);

  always_comb begin
    cmd_d    = cmd_q;
    cpos_d   = cpos_q;
    dpos_d   = dpos_q;
    word_d   = word_q;
    err_d    = err_q;
    clk_lo_d = clk_lo_q;
    clr      = 1'b0;
    if (ctrl_hit) begin
      unique case (ctrl_code_i)
        CTL_RESET: begin
          clr   = 1'b1;
          err_d = 1'b0;
        end
        CTL_CLK_LO: clk_lo_d = 1'b1;
        CTL_CLK_HI: clk_lo_d = 1'b0;
        default: ;
      endcase
    end else if (data_hit) begin
      if (data_code_i == DAT_RD_EN) begin
        dpos_d = '0;
      end else if (clk_lo_q) begin
        if (!cmd_full) begin
          cmd_d  = cmd_q | (CMD_W'(bit_hi) << cpos_q);
          cpos_d = cpos_q + 1'b1;
          if (cpos_q == CPW'(CMD_W - 1)) begin
            if (cmd_d == CMD_CONV) clr = 1'b1;
            else if (cmd_d != CMD_RD_TEMP && cmd_d != CMD_RD_CFG) err_d = 1'b1;
          end
        end else begin
          if (dpos_q < POS_W'(DATA_W)) word_d = word_q | (DATA_W'(bit_hi) << dpos_q);
          if (dpos_q != POS_W'(MAXL)) dpos_d = dpos_q + 1'b1;
        end
      end
    end else if (rd_hit && mode != RM_NONE) begin
      if (dpos_q >= rd_last) clr = 1'b1;
      else dpos_d = dpos_q + 1'b1;
    end
    if (clr) begin
      cmd_d  = '0;
      cpos_d = '0;
      dpos_d = '0;
      word_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q    <= '0;
      cpos_q   <= '0;
      dpos_q   <= '0;
      word_q   <= '0;
      err_q    <= 1'b0;
      clk_lo_q <= 1'b0;
    end else begin
      cmd_q    <= cmd_d;
      cpos_q   <= cpos_d;
      dpos_q   <= dpos_d;
      word_q   <= word_d;
      err_q    <= err_d;
      clk_lo_q <= clk_lo_d;
    end
  end

  assign mode_o    = mode;
  assign pos_o     = dpos_q;
  assign rd_take_o = rd_hit;
  assign clk_low_o = clk_lo_q;
  assign err_o     = err_q;
  assign word_o    = word_q;
endmodule

// File: rtl/thermo_lane_resp.sv
module thermo_lane_resp
  import thermo_pkg::*;
#(
  parameter int unsigned LANES     = 4,
  parameter int unsigned CMD_W     = 8,
  parameter int unsigned TEMP_BITS = 9,
  parameter int unsigned CFG_BITS  = 8,
  parameter int unsigned DATA_W    = 16,
  parameter logic [TEMP_BITS-1:0] TEMP_RST = TEMP_BITS'(44),
  parameter logic [CFG_BITS-1:0]  CFG_RST  = CFG_BITS'(2),
  parameter logic [CMD_W-1:0] CMD_CONV    = 8'hEE,
  parameter logic [CMD_W-1:0] CMD_RD_TEMP = 8'hAA,
  parameter logic [CMD_W-1:0] CMD_RD_CFG  = 8'hAC
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     ctrl_we_i,
  input  logic [1:0]               ctrl_code_i,
  input  logic                     data_we_i,
  input  logic [1:0]               data_code_i,
  input  logic                     rd_i,
  output logic [LANES-1:0]         rd_data_o,
  output logic                     rd_valid_o,
  output logic                     err_o,
  output logic [DATA_W-1:0]        data_word_o,
  input  logic                     side_we_i,
  input  logic                     side_cfg_i,
  input  logic [$clog2(LANES)-1:0] side_idx_i,
  input  logic [TEMP_BITS-1:0]     side_wdata_i
);
  localparam int unsigned MAXRD = (TEMP_BITS > CFG_BITS) ? TEMP_BITS : CFG_BITS;
  localparam int unsigned MAXL  = (DATA_W > MAXRD) ? DATA_W : MAXRD;
  localparam int unsigned POS_W = $clog2(MAXL + 1);

  rd_mode_e         mode;
  logic [POS_W-1:0] pos;
  logic             rd_take;
  logic             clk_low;
  logic [LANES-1:0] temp_bits, cfg_bits;
  logic [LANES-1:0] rd_data_q;
  logic             rd_valid_q;

  thermo_ctrl #(
    .CMD_W(CMD_W), .DATA_W(DATA_W), .TEMP_BITS(TEMP_BITS), .CFG_BITS(CFG_BITS),
    .POS_W(POS_W), .CMD_CONV(CMD_CONV), .CMD_RD_TEMP(CMD_RD_TEMP),
    .CMD_RD_CFG(CMD_RD_CFG)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctrl_we_i   (ctrl_we_i),
    .ctrl_code_i (ctrl_code_i),
    .data_we_i   (data_we_i),
    .data_code_i (data_code_i),
    .rd_i        (rd_i),
    .mode_o      (mode),
    .pos_o       (pos),
    .rd_take_o   (rd_take),
    .clk_low_o   (clk_low),
    .err_o       (err_o),
    .word_o      (data_word_o)
  );

  thermo_sensor_bank #(
    .LANES(LANES), .TEMP_BITS(TEMP_BITS), .CFG_BITS(CFG_BITS), .POS_W(POS_W),
    .TEMP_RST(TEMP_RST), .CFG_RST(CFG_RST)
  ) u_bank (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .side_we_i    (side_we_i),
    .side_cfg_i   (side_cfg_i),
    .side_idx_i   (side_idx_i),
    .side_wdata_i (side_wdata_i),
    .pos_i        (pos),
    .temp_bits_o  (temp_bits),
    .cfg_bits_o   (cfg_bits)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_q  <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      rd_valid_q <= rd_take;
      if (rd_take) begin
        unique case (mode)
          RM_TEMP: rd_data_q <= temp_bits;
          RM_CFG:  rd_data_q <= cfg_bits;
          default: rd_data_q <= '0;
        endcase
      end
    end
  end

  assign rd_data_o  = rd_data_q;
  assign rd_valid_o = rd_valid_q;
endmodule

// File: rtl/thermo_lane_resp_chk.sv
module thermo_lane_resp_chk
  import thermo_pkg::*;
#(
  parameter int unsigned LANES  = 4,
  parameter int unsigned DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ctrl_we_i,
  input logic [1:0]        ctrl_code_i,
  input logic              data_we_i,
  input logic [1:0]        data_code_i,
  input logic              rd_i,
  input logic [LANES-1:0]  rd_data_o,
  input logic              rd_valid_o,
  input logic              err_o,
  input logic [DATA_W-1:0] data_word_o,
  input logic              clk_low
);
  p_valid_after_read_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(rd_i));

  p_data_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_valid_o |-> $stable(rd_data_o));

  p_err_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> $past(data_we_i && !ctrl_we_i));

  p_reset_code_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_i && ctrl_code_i == CTL_RESET) |=> (!err_o && data_word_o == '0));

  p_clk_high_ignore_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_we_i && !ctrl_we_i && !clk_low && data_code_i != DAT_RD_EN)
      |=> ($stable(data_word_o) && $stable(err_o)));

  p_ctrl_over_read_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_i && rd_i) |=> !rd_valid_o);
endmodule

bind thermo_lane_resp thermo_lane_resp_chk #(.LANES(LANES), .DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ctrl_we_i   (ctrl_we_i),
  .ctrl_code_i (ctrl_code_i),
  .data_we_i   (data_we_i),
  .data_code_i (data_code_i),
  .rd_i        (rd_i),
  .rd_data_o   (rd_data_o),
  .rd_valid_o  (rd_valid_o),
  .err_o       (err_o),
  .data_word_o (data_word_o),
  .clk_low     (clk_low)
);

// File: tb/sim_thermo_lane_resp.sv
`timescale 1ns/1ps
module sim_thermo_lane_resp;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ctrl_we_i = 1'b0;
  logic [1:0]  ctrl_code_i = 2'd3;
  logic        data_we_i = 1'b0;
  logic [1:0]  data_code_i = 2'd0;
  logic        rd_i = 1'b0;
  logic [3:0]  rd_data_o;
  logic        rd_valid_o;
  logic        err_o;
  logic [15:0] data_word_o;
  logic        side_we_i = 1'b0;
  logic        side_cfg_i = 1'b0;
  logic [1:0]  side_idx_i = 2'd0;
  logic [8:0]  side_wdata_i = 9'd0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [3:0] exp_q[$];
  string      tag_q[$];
  logic [8:0] tm[4];
  logic [7:0] cm[4];

  always #4 clk_i = ~clk_i;

  thermo_lane_resp u0 (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .ctrl_we_i(ctrl_we_i), .ctrl_code_i(ctrl_code_i),
    .data_we_i(data_we_i), .data_code_i(data_code_i),
    .rd_i(rd_i), .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o),
    .err_o(err_o), .data_word_o(data_word_o),
    .side_we_i(side_we_i), .side_cfg_i(side_cfg_i),
    .side_idx_i(side_idx_i), .side_wdata_i(side_wdata_i)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(posedge clk_i) begin
    #1;
    if (rst_ni && rd_valid_o) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R11/R12 unexpected read result actual=%0h expected=none", rd_data_o);
      end else begin
        logic [3:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rd_data_o !== e) begin
          fails++;
          $display("FAIL %s actual=%0h expected=%0h", t, rd_data_o, e);
        end
      end
    end
  end

  task automatic ctrl(input logic [1:0] c);
    @(negedge clk_i);
    ctrl_we_i = 1'b1; ctrl_code_i = c;
    @(negedge clk_i);
    ctrl_we_i = 1'b0; ctrl_code_i = 2'd3;
  endtask

  task automatic dat(input logic [1:0] c);
    @(negedge clk_i);
    data_we_i = 1'b1; data_code_i = c;
    @(negedge clk_i);
    data_we_i = 1'b0;
  endtask

  task automatic send_cmd(input logic [7:0] c);
    for (int i = 0; i < 8; i++) dat(c[i] ? 2'd1 : 2'd0);
  endtask

  task automatic rd_expect(input logic [3:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk_i);
    rd_i = 1'b1;
    @(negedge clk_i);
    rd_i = 1'b0;
  endtask

  function automatic logic [3:0] tbit(input int k);
    logic [3:0] r;
    for (int i = 0; i < 4; i++) r[i] = (k < 9) ? tm[i][k] : 1'b0;
    return r;
  endfunction

  function automatic logic [3:0] cbit(input int k);
    logic [3:0] r;
    for (int i = 0; i < 4; i++) r[i] = (k < 8) ? cm[i][k] : 1'b0;
    return r;
  endfunction

  task automatic side(input bit is_cfg, input int idx, input logic [8:0] v);
    @(negedge clk_i);
    side_we_i = 1'b1; side_cfg_i = is_cfg; side_idx_i = 2'(idx); side_wdata_i = v;
    @(negedge clk_i);
    side_we_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin tm[i] = 9'd44; cm[i] = 8'h02; end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1 rd_data", 32'(rd_data_o), 0);
    chk("R1 rd_valid", 32'(rd_valid_o), 0);
    chk("R1 err", 32'(err_o), 0);
    chk("R1 data_word", 32'(data_word_o), 0);

    // R4/R1 default temperature, then boundary read
    ctrl(2'd1);
    send_cmd(8'hAA);
    for (int k = 0; k < 9; k++) rd_expect(tbit(k), "R4/R1 default temp");
    rd_expect(4'h0, "R4/R11 read after ninth");

    // R1 default configuration through R5
    send_cmd(8'hAC);
    for (int k = 0; k < 8; k++) rd_expect(cbit(k), "R5/R1 default cfg");
    rd_expect(4'h0, "R5 read after eighth");

    // R10 side port loads
    tm[0] = 9'h1A5; tm[1] = 9'h05A; tm[2] = 9'h0F0; tm[3] = 9'h133;
    cm[0] = 8'h81;  cm[1] = 8'h3C;  cm[2] = 8'hE7;  cm[3] = 8'h5A;
    for (int i = 0; i < 4; i++) begin side(1'b0, i, tm[i]); side(1'b1, i, {1'b0, cm[i]}); end
    send_cmd(8'hAA);
    for (int k = 0; k < 9; k++) rd_expect(tbit(k), "R10/R4 lane temp");
    rd_expect(4'h0, "R4 boundary");
    send_cmd(8'hAC);
    for (int k = 0; k < 8; k++) rd_expect(cbit(k), "R10/R5 lane cfg");
    rd_expect(4'h0, "R5 boundary");

    // R2 bits ignored while clock flag clear
    ctrl(2'd2);
    send_cmd(8'hFF);
    @(negedge clk_i);
    chk("R2 err after ignored bits", 32'(err_o), 0);
    rd_expect(4'h0, "R2 no command taken");
    ctrl(2'd1);
    send_cmd(8'hAA);
    rd_expect(tbit(0), "R2 command after clock low");

    // R6 read enable rewinds, keeps command
    rd_expect(tbit(1), "R6 pre");
    rd_expect(tbit(2), "R6 pre");
    ctrl(2'd2);
    dat(2'd2);
    ctrl(2'd1);
    for (int k = 0; k < 9; k++) rd_expect(tbit(k), "R6 rewind");
    rd_expect(4'h0, "R6 boundary after rewind");

    // R7 data accumulation, R9 reset clears it
    send_cmd(8'hAA);
    dat(2'd1); dat(2'd0); dat(2'd1); dat(2'd1);
    @(negedge clk_i);
    chk("R7 data word", 32'(data_word_o), 32'hD);
    ctrl(2'd0);
    @(negedge clk_i);
    chk("R9 data word cleared", 32'(data_word_o), 0);

    // R8 unknown command
    send_cmd(8'h55);
    @(negedge clk_i);
    chk("R8 err set", 32'(err_o), 1);
    rd_expect(4'h0, "R8 read zero");
    ctrl(2'd0);
    @(negedge clk_i);
    chk("R9 err cleared", 32'(err_o), 0);

    // R9 clock flag kept across reset code
    send_cmd(8'hAA);
    rd_expect(tbit(0), "R9 clock flag kept");

    // R3 start conversion clears shift state
    ctrl(2'd0);
    send_cmd(8'hEE);
    @(negedge clk_i);
    chk("R3 no error", 32'(err_o), 0);
    rd_expect(4'h0, "R3 no read mode");
    send_cmd(8'hAA);
    rd_expect(tbit(0), "R3 new command at once");

    // R12 priority: ctrl beats read, data beats read
    @(negedge clk_i);
    ctrl_we_i = 1'b1; ctrl_code_i = 2'd1; rd_i = 1'b1;
    @(negedge clk_i);
    ctrl_we_i = 1'b0; ctrl_code_i = 2'd3; rd_i = 1'b0;
    chk("R12 ctrl wins", 32'(rd_valid_o), 0);
    @(negedge clk_i);
    data_we_i = 1'b1; data_code_i = 2'd2; rd_i = 1'b1;
    @(negedge clk_i);
    data_we_i = 1'b0; rd_i = 1'b0;
    chk("R12 data wins", 32'(rd_valid_o), 0);
    rd_expect(tbit(0), "R12/R6 position after rewind");
    rd_expect(tbit(1), "R12 next position");

    repeat (4) @(negedge clk_i);
    chk("R11 scoreboard drained", 32'(exp_q.size()), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule